// File: doc/BRIEF.md
# TLB Shootdown Coordination Controller

This block sequences a translation invalidation across a group of cores that share one address space. A request carries a page-table-entry identifier, the virtual page number whose translation is changing, and a conservative bitmask of the cores that might cache that translation. The controller locks the page-table entry first. It then interrupts every targeted remote core, invalidates the initiating core's own TLB entry, and waits for every remote core to acknowledge. Only after the last acknowledge does it release the lock and report completion.

Each remote core has a responder inside the block. The responder latches the interrupt, holds an invalidate request toward that core's TLB until the TLB reports the invalidate as done, and then answers with a one-cycle acknowledge. The initiating core's TLB uses the same request/done pins at its own index, driven by the sequencer. The block also reports how many cycles the last shootdown kept it busy.

Top module: `tlbsd_top`

## Requirements
- R1: During and after reset `busy`, `lock_req`, `unlock`, `done`, `ipi`, `core_ack` and `latency` are 0 and `req_ready` is 1.
- R2: A request is taken only when `req_ready` is 1, and `busy` rises on the next cycle. `req_valid` while busy is ignored: no field of it reaches any output, and no second shootdown starts once the first ends.
- R3: `lock_req` is the first action of a shootdown. No `ipi` bit is set before a cycle in which `lock_req` and `lock_grant` were both 1. `lock_pte` shows the request's identifier for the whole busy period.
- R4: The cycle after the grant, `ipi` is driven for exactly one cycle with the request mask minus bit `SELF_ID`. Bit i of every mask refers to core i.
- R5: After the interrupts, `tlb_inv_req[SELF_ID]` is held until `tlb_inv_done[SELF_ID]` is seen. While any invalidate request is high, `tlb_inv_vpn` equals the request's page number.
- R6: A remote responder that received an interrupt holds `tlb_inv_req[i]` until `tlb_inv_done[i]`. It then pulses `core_ack[i]` for one cycle on the next cycle, once per shootdown.
- R7: `tlb_inv_done[i]` from a core with no pending interrupt, and a done held high after it was taken, produce no acknowledge and do not end the wait.
- R8: `unlock` and `done` pulse together for one cycle, only after the local invalidate and all targeted acknowledges. `busy` falls on the next cycle.
- R9: If the mask is empty after the initiator bit is removed, `unlock` follows the cycle after the local invalidate completes.
- R10: After a shootdown, `latency` equals the number of cycles `busy` was 1, saturating at its maximum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Shootdown request strobe |
| req_pte | input | PTE_W | Page-table-entry identifier |
| req_vpn | input | VPN_W | Virtual page number to invalidate |
| req_targets | input | N_CORES | Cores that may hold the translation |
| req_ready | output | 1 | Controller idle, request will be taken |
| busy | output | 1 | Shootdown in progress |
| done | output | 1 | One-cycle completion pulse |
| lock_req | output | 1 | Request to lock the entry |
| lock_pte | output | PTE_W | Entry identifier for lock and unlock |
| lock_grant | input | 1 | Lock granted |
| unlock | output | 1 | One-cycle unlock pulse |
| ipi | output | N_CORES | Invalidate interrupt per core |
| tlb_inv_req | output | N_CORES | Invalidate request per core TLB |
| tlb_inv_vpn | output | VPN_W | Page number being invalidated |
| tlb_inv_done | input | N_CORES | Invalidate finished, per core TLB |
| core_ack | output | N_CORES | Acknowledge pulse per remote core |
| latency | output | LAT_W | Busy cycles of the last shootdown |

## Verification
The shootdown runs with a full mask whose remote acknowledges arrive while the local invalidate is still busy, and with a mask that includes the initiator, which shows that the self bit is stripped. Two masks that become empty, one holding only the initiator and one all zero, show the direct path from local invalidate to unlock. A run with spread-out acknowledge delays, a done held for three cycles, a stray done from an untargeted core and a request made while busy shows that only genuine first acknowledges end the wait and that nothing queues behind a busy shootdown. Lock-grant delay varies between runs, which separates "interrupts after grant" from a fixed cycle count.

// File: rtl/tlbsd_pkg.sv
package tlbsd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOCK,
    ST_SEND,
    ST_LOCAL,
    ST_WAIT,
    ST_UNLOCK
  } sd_state_t;
endpackage

// File: rtl/tlbsd_responder.sv
// Remote-core responder: latches an interrupt, holds the TLB invalidate
// request until the TLB reports done, then acknowledges for one cycle.
module tlbsd_responder (
  input  logic clk,
  input  logic rst,
  input  logic irq,
  input  logic inv_done,
  output logic inv_req,
  output logic ack
);
  logic pend_q;
  logic ack_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      ack_q  <= 1'b0;
    end else begin
      ack_q <= pend_q & inv_done;
      if (irq)
        pend_q <= 1'b1;
      else if (pend_q && inv_done)
        pend_q <= 1'b0;
    end
  end

  assign inv_req = pend_q;
  assign ack     = ack_q;
endmodule

// File: rtl/tlbsd_ack_tracker.sv
// Pending-acknowledge mask: loaded from the target mask, cleared per ack.
module tlbsd_ack_tracker #(
  parameter int N_CORES = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [N_CORES-1:0] load_mask,
  input  logic [N_CORES-1:0] ack,
  output logic [N_CORES-1:0] pending_next
);
  logic [N_CORES-1:0] pending_q;

  assign pending_next = pending_q & ~ack;

  always_ff @(posedge clk) begin
    if (rst)
      pending_q <= '0;
    else if (load)
      pending_q <= load_mask;
    else
      pending_q <= pending_next;
  end
endmodule

// File: rtl/tlbsd_seq.sv
// Initiator sequencer: lock, interrupt, local invalidate, wait, unlock.
module tlbsd_seq
  import tlbsd_pkg::*;
#(
  parameter int N_CORES = 4,
  parameter int SELF_ID = 0,
  parameter int PTE_W   = 8,
  parameter int VPN_W   = 12,
  parameter int LAT_W   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [PTE_W-1:0]   req_pte,
  input  logic [VPN_W-1:0]   req_vpn,
  input  logic [N_CORES-1:0] req_targets,
  input  logic               lock_grant,
  input  logic               local_done,
  input  logic [N_CORES-1:0] pending_next,
  output logic               req_ready,
  output logic               busy,
  output logic               done,
  output logic               lock_req,
  output logic               unlock,
  output logic [PTE_W-1:0]   lock_pte,
  output logic [VPN_W-1:0]   inv_vpn,
  output logic [N_CORES-1:0] ipi,
  output logic               load,
  output logic [N_CORES-1:0] load_mask,
  output logic               local_req,
  output logic [LAT_W-1:0]   latency
);
  localparam logic [N_CORES-1:0] SELF_BIT = {{(N_CORES-1){1'b0}}, 1'b1} << SELF_ID;
  localparam logic [LAT_W-1:0]   LAT_MAX  = '1;

  sd_state_t          state_q, state_d;
  logic [PTE_W-1:0]   pte_q;
  logic [VPN_W-1:0]   vpn_q;
  logic [N_CORES-1:0] mask_q;
  logic [LAT_W-1:0]   cnt_q;
  logic [LAT_W-1:0]   lat_q;

  assign load      = req_valid && (state_q == ST_IDLE);
  assign load_mask = req_targets & ~SELF_BIT;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:   if (req_valid) state_d = ST_LOCK;
      ST_LOCK:   if (lock_grant) state_d = ST_SEND;
      ST_SEND:   state_d = ST_LOCAL;
      ST_LOCAL:  if (local_done)
                   state_d = (pending_next == '0) ? ST_UNLOCK : ST_WAIT;
      ST_WAIT:   if (pending_next == '0) state_d = ST_UNLOCK;
      ST_UNLOCK: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      pte_q   <= '0;
      vpn_q   <= '0;
      mask_q  <= '0;
      cnt_q   <= '0;
      lat_q   <= '0;
    end else begin
      state_q <= state_d;
      if (load) begin
        pte_q  <= req_pte;
        vpn_q  <= req_vpn;
        mask_q <= load_mask;
        cnt_q  <= {{(LAT_W-1){1'b0}}, 1'b1};
      end else if (state_q != ST_IDLE && cnt_q != LAT_MAX) begin
        cnt_q <= cnt_q + 1'b1;
      end
      if (state_q == ST_UNLOCK)
        lat_q <= cnt_q;
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign busy      = (state_q != ST_IDLE);
  assign lock_req  = (state_q == ST_LOCK);
  assign unlock    = (state_q == ST_UNLOCK);
  assign done      = (state_q == ST_UNLOCK);
  assign local_req = (state_q == ST_LOCAL);
  assign ipi       = (state_q == ST_SEND) ? mask_q : '0;
  assign lock_pte  = pte_q;
  assign inv_vpn   = vpn_q;
  assign latency   = lat_q;
endmodule

// File: rtl/tlbsd_top.sv
module tlbsd_top #(
  parameter int N_CORES = 4,
  parameter int SELF_ID = 0,
  parameter int PTE_W   = 8,
  parameter int VPN_W   = 12,
  parameter int LAT_W   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [PTE_W-1:0]   req_pte,
  input  logic [VPN_W-1:0]   req_vpn,
  input  logic [N_CORES-1:0] req_targets,
  output logic               req_ready,
  output logic               busy,
  output logic               done,
  output logic               lock_req,
  output logic [PTE_W-1:0]   lock_pte,
  input  logic               lock_grant,
  output logic               unlock,
  output logic [N_CORES-1:0] ipi,
  output logic [N_CORES-1:0] tlb_inv_req,
  output logic [VPN_W-1:0]   tlb_inv_vpn,
  input  logic [N_CORES-1:0] tlb_inv_done,
  output logic [N_CORES-1:0] core_ack,
  output logic [LAT_W-1:0]   latency
);
  logic               load;
  logic [N_CORES-1:0] load_mask;
  logic [N_CORES-1:0] pending_next;
  logic               local_req;

  tlbsd_seq #(
    .N_CORES(N_CORES), .SELF_ID(SELF_ID), .PTE_W(PTE_W),
    .VPN_W(VPN_W), .LAT_W(LAT_W)
  ) u_seq (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_pte(req_pte), .req_vpn(req_vpn),
    .req_targets(req_targets), .lock_grant(lock_grant),
    .local_done(tlb_inv_done[SELF_ID]), .pending_next(pending_next),
    .req_ready(req_ready), .busy(busy), .done(done),
    .lock_req(lock_req), .unlock(unlock), .lock_pte(lock_pte),
    .inv_vpn(tlb_inv_vpn), .ipi(ipi), .load(load),
    .load_mask(load_mask), .local_req(local_req), .latency(latency)
  );

  tlbsd_ack_tracker #(.N_CORES(N_CORES)) u_track (
    .clk(clk), .rst(rst), .load(load), .load_mask(load_mask),
    .ack(core_ack), .pending_next(pending_next)
  );

  for (genvar g = 0; g < N_CORES; g++) begin : g_core
    if (g == SELF_ID) begin : g_self
      assign tlb_inv_req[g] = local_req;
      assign core_ack[g]    = 1'b0;
    end else begin : g_remote
      tlbsd_responder u_resp (
        .clk(clk), .rst(rst), .irq(ipi[g]), .inv_done(tlb_inv_done[g]),
        .inv_req(tlb_inv_req[g]), .ack(core_ack[g])
      );
    end
  end
endmodule

// File: rtl/tlbsd_chk.sv
module tlbsd_chk #(
  parameter int N_CORES = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               lock_req,
  input logic               lock_grant,
  input logic               unlock,
  input logic               busy,
  input logic [N_CORES-1:0] ipi,
  input logic [N_CORES-1:0] core_ack
);
  logic               locked_q;
  logic [N_CORES-1:0] outstanding_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      locked_q      <= 1'b0;
      outstanding_q <= '0;
    end else begin
      if (lock_req && lock_grant) locked_q <= 1'b1;
      else if (unlock)            locked_q <= 1'b0;
      outstanding_q <= (outstanding_q | ipi) & ~core_ack;
    end
  end

  // R3
  ipi_after_grant_chk: assert property (@(posedge clk) disable iff (rst)
    (ipi != '0) |-> locked_q);

  // R4
  ipi_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (ipi != '0) |=> (ipi == '0));

  // R6
  ack_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (core_ack & $past(core_ack)) == '0);

  // R8
  unlock_after_acks_chk: assert property (@(posedge clk) disable iff (rst)
    unlock |-> (outstanding_q == '0));

  // R8
  unlock_ends_busy_chk: assert property (@(posedge clk) disable iff (rst)
    unlock |=> !busy);
endmodule

bind tlbsd_top tlbsd_chk #(.N_CORES(N_CORES)) u_chk (
  .clk(clk), .rst(rst), .lock_req(lock_req), .lock_grant(lock_grant),
  .unlock(unlock), .busy(busy), .ipi(ipi), .core_ack(core_ack)
);

// File: tb/tlbsd_top_test.sv
module tlbsd_top_test;
  localparam int PERIOD = 10;
  localparam int N = 4;

  typedef struct packed {
    logic [7:0]  pte;
    logic [11:0] vpn;
    logic [3:0]  mask;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req_valid = 1'b0;
  logic [7:0]   req_pte = '0;
  logic [11:0]  req_vpn = '0;
  logic [3:0]   req_targets = '0;
  logic         lock_grant = 1'b0;
  logic [3:0]   tlb_inv_done;
  logic [3:0]   stray_done = '0;
  logic         req_ready, busy, done, lock_req, unlock;
  logic [7:0]   lock_pte;
  logic [3:0]   ipi, tlb_inv_req, core_ack;
  logic [11:0]  tlb_inv_vpn;
  logic [15:0]  latency;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int gdly = 0;
  int dly [N];
  int hold [N];
  exp_t exp_q [$];

  always #(PERIOD/2) clk = ~clk;

  tlbsd_top uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_pte(req_pte),
    .req_vpn(req_vpn), .req_targets(req_targets), .req_ready(req_ready),
    .busy(busy), .done(done), .lock_req(lock_req), .lock_pte(lock_pte),
    .lock_grant(lock_grant), .unlock(unlock), .ipi(ipi),
    .tlb_inv_req(tlb_inv_req), .tlb_inv_vpn(tlb_inv_vpn),
    .tlb_inv_done(tlb_inv_done), .core_ack(core_ack), .latency(latency)
  );

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  // Lock owner model
  initial begin
    forever begin
      @(negedge clk);
      if (lock_req && !lock_grant) begin
        repeat (gdly) @(negedge clk);
        lock_grant = 1'b1;
        @(negedge clk);
        lock_grant = 1'b0;
      end
    end
  end

  // Per-core TLB models
  for (genvar g = 0; g < N; g++) begin : emu
    logic d = 1'b0;
    assign tlb_inv_done[g] = d | stray_done[g];
    initial begin
      forever begin
        @(negedge clk);
        if (tlb_inv_req[g] && !d) begin
          repeat (dly[g]) @(negedge clk);
          d = 1'b1;
          repeat (hold[g]) @(negedge clk);
          d = 1'b0;
        end
      end
    end
  end

  // Driver: issue one shootdown and record what is expected of it
  task automatic shoot(input logic [7:0] p, input logic [11:0] v, input logic [3:0] m);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_pte = p; req_vpn = v; req_targets = m;
    exp_q.push_back('{pte: p, vpn: v, mask: m & 4'b1110});
    @(negedge clk);
    req_valid = 1'b0;
    while (busy || exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // Monitor / scoreboard, sampled a quarter period after the falling edge
  initial begin
    exp_t cur;
    bit prev_busy, granted, local_fired, local_started, lf_prev, lat_due;
    int bcount;
    logic [3:0] seen_ipi;
    int ackcnt [N];
    cur = '0; prev_busy = 0; granted = 0; local_fired = 0; local_started = 0;
    lf_prev = 0; lat_due = 0; bcount = 0; seen_ipi = '0;
    foreach (ackcnt[i]) ackcnt[i] = 0;
    forever begin
      @(negedge clk);
      #(PERIOD/4);
      if (!rst) begin
        if (lat_due) begin
          lat_due = 0;
          chk(!busy, "R8 busy low after unlock", busy, 0);
          chk(latency == 16'(bcount), "R10 latency", latency, bcount);
        end
        if (busy && !prev_busy) begin
          bcount = 0; seen_ipi = '0; granted = 0; local_fired = 0;
          local_started = 0; lf_prev = 0;
          foreach (ackcnt[i]) ackcnt[i] = 0;
          if (exp_q.size() == 0) chk(0, "R2 start without accepted request", 1, 0);
          else cur = exp_q[0];
        end
        prev_busy = busy;
        if (busy) bcount++;
        if (lf_prev && cur.mask == 4'b0000)
          chk(unlock, "R9 unlock right after local invalidate", unlock, 1);
        lf_prev = tlb_inv_req[0] && tlb_inv_done[0];
        if (lf_prev) local_fired = 1;
        if (ipi != '0) chk(granted, "R3 interrupt before grant", granted, 1);
        seen_ipi |= ipi;
        if (tlb_inv_req[0] && !local_started) begin
          local_started = 1;
          chk(tlb_inv_vpn == cur.vpn, "R5 invalidate page", tlb_inv_vpn, cur.vpn);
          chk(seen_ipi == cur.mask, "R5 local invalidate after interrupts", seen_ipi, cur.mask);
        end
        for (int i = 0; i < N; i++) if (core_ack[i]) ackcnt[i]++;
        if (lock_req && lock_grant) granted = 1;
        if (unlock) begin
          chk(done, "R8 done with unlock", done, 1);
          chk(lock_pte == cur.pte, "R3 lock entry id", lock_pte, cur.pte);
          chk(seen_ipi == cur.mask, "R4 interrupt mask", seen_ipi, cur.mask);
          chk(local_fired, "R5 local invalidate before unlock", local_fired, 1);
          for (int i = 1; i < N; i++) begin
            if (cur.mask[i]) chk(ackcnt[i] == 1, "R6 one ack per target", ackcnt[i], 1);
            else             chk(ackcnt[i] == 0, "R7 no ack from non-target", ackcnt[i], 0);
          end
          if (exp_q.size() != 0) void'(exp_q.pop_front());
          lat_due = 1;
        end
      end
    end
  end

  initial begin
    foreach (dly[i]) begin dly[i] = 0; hold[i] = 1; end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && req_ready, "R1 idle in reset", {busy, req_ready}, 2'b01);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && req_ready, "R1 idle after reset", {busy, req_ready}, 2'b01);
    chk(ipi == 0 && core_ack == 0, "R1 no interrupts or acks", {ipi, core_ack}, 0);
    chk(!lock_req && !unlock && !done, "R1 lock outputs low", {lock_req, unlock, done}, 0);
    chk(latency == 0, "R1 latency zero", latency, 0);

    // Remote targets with spread delays
    gdly = 2; dly = '{1, 2, 0, 3};
    shoot(8'h11, 12'h123, 4'b1110);
    // Initiator bit in the mask is stripped (R4)
    gdly = 0; dly = '{0, 1, 0, 0};
    shoot(8'h22, 12'h456, 4'b0011);
    // Only the initiator: empty after stripping (R9)
    shoot(8'h33, 12'h789, 4'b0001);
    // Fully empty mask with a slow local invalidate (R9)
    dly = '{3, 0, 0, 0};
    shoot(8'h44, 12'habc, 4'b0000);
    // Slow acks, held done, stray done, request while busy (R2, R7)
    gdly = 1; dly = '{0, 6, 4, 0}; hold = '{1, 3, 1, 1};
    fork
      shoot(8'h55, 12'hdef, 4'b0110);
      begin
        repeat (3) @(negedge clk);
        stray_done[3] = 1'b1;
        req_valid = 1'b1; req_pte = 8'hee; req_vpn = 12'h999; req_targets = 4'b1111;
        repeat (2) @(negedge clk);
        stray_done[3] = 1'b0;
        req_valid = 1'b0;
      end
    join
    repeat (4) @(negedge clk);
    chk(!busy, "R2 request made while busy was not queued", busy, 0);
    // Acks arrive while the local invalidate is still pending
    gdly = 0; dly = '{5, 0, 0, 0}; hold = '{1, 1, 1, 1};
    shoot(8'h66, 12'h0f0, 4'b1111);
    repeat (3) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule